// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for an 8-bit processor core and decides which one the core takes next. It has five sources. The first is a non-maskable trap that is detected on a rising edge. The next three are maskable restart sources, each with its own fixed restart vector: two respond to the level of their input and one is latched on a rising edge. The last is a general request that has no vector of its own and is answered with an acknowledge pulse. The block holds the three mask bits, the global interrupt-enable flip-flop and the serial output bit. It also holds the latches for the two edge-sensitive inputs.

Each cycle, a fixed priority picks a single eligible source. The block presents that source as a one-hot source code with its 16-bit vector. The core accepts the request by raising `ack_i` while `req_o` is high. Software programs the block through a set-mask write word and reads it back through a status word. Instruction decode and pushing the return address belong to the core.

Top module: `prio_vec_intc`

## Requirements
- R1: A rising edge on `trap_i` sets a trap pending latch. While that latch is set, the trap is presented on the next cycle and every cycle after, whatever the masks and the enable flip-flop hold. The trap vector is 0x0024. Accepting the trap clears the latch.
- R2: The priority order is trap, then the edge restart source (`edge_hi_i`), then `lvl_mid_i`, then `lvl_lo_i`, then `ext_req_i`. `src_o` is one-hot: bit0 is trap, bit1 is the edge restart source, bit2 is mid, bit3 is lo and bit4 is the general request. `req_o` is high exactly when some source is eligible.
- R3: The vectors are trap 0x0024, lo 0x002C, mid 0x0034 and edge restart source 0x003C. For the general request, `vectored_o` is 0 and `vec_o` is 0x0000.
- R4: A maskable source whose mask bit is 1 is never presented. Reset sets all three mask bits to 1.
- R5: The three maskable sources and the general request are presented only while the enable flip-flop is 1. `ie_set_i` sets the flip-flop and `ie_clr_i` clears it. Reset clears it.
- R6: Acceptance (`ack_i` while `req_o` is high) clears the enable flip-flop, whichever source is accepted. If acceptance or `ie_clr_i` arrives in the same cycle as `ie_set_i`, the flip-flop is cleared.
- R7: The edge restart latch is set by a rising edge on `edge_hi_i`. It is cleared when that source is accepted, or by a set-mask write with bit4 = 1. A new edge in the same cycle as a clear leaves the latch set.
- R8: A set-mask write (`sm_wr_i`) with bit3 = 1 loads the masks from bit0 (lo), bit1 (mid) and bit2 (edge restart). When bit3 = 0, the masks are unchanged.
- R9: A set-mask write with bit6 = 1 loads bit7 into `ser_out_o`. When bit6 = 0, `ser_out_o` is unchanged. Reset value is 0.
- R10: `stat_o` is laid out as follows. Bits 2:0 are the masks (lo, mid, edge restart). Bit3 is the enable flip-flop. Bit4 is the `lvl_lo_i` level, bit5 is the `lvl_mid_i` level and bit6 is the edge restart latch; these three pending bits are shown whatever the masks hold. Bit7 is `ser_in_i`.
- R11: `int_ack_o` is high only in a cycle where the general request is the accepted winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap, rising edge |
| edge_hi_i | input | 1 | Edge-latched restart request |
| lvl_mid_i | input | 1 | Level restart request, middle rank |
| lvl_lo_i | input | 1 | Level restart request, lowest restart rank |
| ext_req_i | input | 1 | General non-vectored request |
| ack_i | input | 1 | Core accepts the presented request |
| ie_set_i | input | 1 | Enable-interrupts strobe |
| ie_clr_i | input | 1 | Disable-interrupts strobe |
| sm_wr_i | input | 1 | Set-mask write strobe |
| sm_data_i | input | 8 | Set-mask write word |
| ser_in_i | input | 1 | Serial input bit |
| ser_out_o | output | 1 | Serial output bit |
| stat_o | output | 8 | Read-mask status word |
| req_o | output | 1 | A request is presented |
| src_o | output | 5 | One-hot winning source |
| vec_o | output | 16 | Restart vector of the winner |
| vectored_o | output | 1 | Winner has a fixed vector |
| int_ack_o | output | 1 | Acknowledge for the general request |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that `trap_i` and `edge_hi_i` are low while reset is applied, so that no edge is seen at reset release. The bench drives every input just after the falling edge and holds all inputs low during reset. The random phase drives the trap rarely and tries all set-mask words, so the lower-ranked sources still win some cycles and the mask-set and serial qualifiers are reached with both values.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 5;
  localparam int NMASK = 3;
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;
  localparam int VEC_STEP = 8;

  // priority index: lower wins
  localparam int SRC_TRAP = 0;
  localparam int SRC_EDGE = 1;
  localparam int SRC_MID  = 2;
  localparam int SRC_LO   = 3;
  localparam int SRC_GEN  = 4;

  // vector slot of each vectored source, vector = base + step*slot
  function automatic logic [VEC_W-1:0] vec_of(input int src);
    int slot;
    case (src)
      SRC_TRAP: slot = 0;
      SRC_LO:   slot = 1;
      SRC_MID:  slot = 2;
      default:  slot = 3;
    endcase
    return VEC_BASE + VEC_W'(VEC_STEP * slot);
  endfunction
endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q;
  logic rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      q_o    <= rise | (q_o & ~clr_i);
    end
  end

  // R7
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(lvl_i && !prev_q)) |=> !q_o);
  // R1
  edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !prev_q) |=> q_o);
endmodule

// File: rtl/intc_mask_regs.sv
module intc_mask_regs #(
  parameter int NM = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          accept_i,
  output logic [NM-1:0] mask_o,
  output logic          ie_o,
  output logic          sod_o
);
  localparam int MSE_BIT = NM;
  localparam int SDE_BIT = DW - 2;
  localparam int SOD_BIT = DW - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      ie_o   <= 1'b0;
      sod_o  <= 1'b0;
    end else begin
      if (wr_i && wr_data_i[MSE_BIT]) mask_o <= wr_data_i[NM-1:0];
      if (wr_i && wr_data_i[SDE_BIT]) sod_o  <= wr_data_i[SOD_BIT];
      if (accept_i || di_i)           ie_o   <= 1'b0;
      else if (ei_i)                  ie_o   <= 1'b1;
    end
  end

  // R6
  accept_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !ie_o);
  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && wr_data_i[MSE_BIT])) |=> $stable(mask_o));
  // R9
  sod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && wr_data_i[SDE_BIT])) |=> $stable(sod_o));
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]  = elig_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic             edge_hi_i,
  input  logic             lvl_mid_i,
  input  logic             lvl_lo_i,
  input  logic             ext_req_i,
  input  logic             ack_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             sm_wr_i,
  input  logic [7:0]       sm_data_i,
  input  logic             ser_in_i,
  output logic             ser_out_o,
  output logic [7:0]       stat_o,
  output logic             req_o,
  output logic [NSRC-1:0]  src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vectored_o,
  output logic             int_ack_o
);
  localparam int CLR_EDGE_BIT = NMASK + 1;

  logic [NMASK-1:0] mask;
  logic             ie;
  logic             trap_pend, edge_pend;
  logic [NSRC-1:0]  elig, gnt;
  logic             accept;

  assign accept = ack_i & req_o;

  intc_edge_latch u_trap_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (trap_i),
    .clr_i (accept & gnt[SRC_TRAP]), .q_o (trap_pend)
  );

  intc_edge_latch u_edge_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (edge_hi_i),
    .clr_i ((accept & gnt[SRC_EDGE]) | (sm_wr_i & sm_data_i[CLR_EDGE_BIT])),
    .q_o   (edge_pend)
  );

  intc_mask_regs #(.NM(NMASK), .DW(8)) u_mask_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (sm_wr_i), .wr_data_i (sm_data_i),
    .ei_i (ie_set_i), .di_i (ie_clr_i), .accept_i (accept),
    .mask_o (mask), .ie_o (ie), .sod_o (ser_out_o)
  );

  assign elig[SRC_TRAP] = trap_pend;
  assign elig[SRC_EDGE] = edge_pend & ~mask[2] & ie;
  assign elig[SRC_MID]  = lvl_mid_i & ~mask[1] & ie;
  assign elig[SRC_LO]   = lvl_lo_i  & ~mask[0] & ie;
  assign elig[SRC_GEN]  = ext_req_i & ie;

  intc_prio_arb #(.N(NSRC)) u_arb (
    .elig_i (elig), .gnt_o (gnt), .any_o (req_o)
  );

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < SRC_GEN; i++)
      if (gnt[i]) vec_o = vec_o | vec_of(i);
  end

  assign src_o      = gnt;
  assign vectored_o = req_o & ~gnt[SRC_GEN];
  assign int_ack_o  = accept & gnt[SRC_GEN];
  assign stat_o     = {ser_in_i, edge_pend, lvl_mid_i, lvl_lo_i, ie, mask};

  // R1
  trap_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pend |-> (req_o && src_o[SRC_TRAP] && vec_o == VEC_BASE));
  // R5
  ie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie && !trap_pend) |-> !req_o);
  // R4
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !((src_o[SRC_LO] && mask[0]) || (src_o[SRC_MID] && mask[1]) ||
                (src_o[SRC_EDGE] && mask[2])));
  // R11
  gen_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |-> (ack_i && src_o[SRC_GEN] && !vectored_o));
  // R2
  one_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_o) && (req_o == (src_o != '0)));
endmodule

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap, e_hi, l_mid, l_lo, gen, ack, ei, di, wr, sin;
  logic [7:0] wd;
  logic sout, req, vtd, iack;
  logic [7:0] stat;
  logic [4:0] src;
  logic [15:0] vec;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk_i (clk), .rst_ni (rst_n), .trap_i (trap), .edge_hi_i (e_hi),
    .lvl_mid_i (l_mid), .lvl_lo_i (l_lo), .ext_req_i (gen), .ack_i (ack),
    .ie_set_i (ei), .ie_clr_i (di), .sm_wr_i (wr), .sm_data_i (wd),
    .ser_in_i (sin), .ser_out_o (sout), .stat_o (stat), .req_o (req),
    .src_o (src), .vec_o (vec), .vectored_o (vtd), .int_ack_o (iack)
  );

  // reference model state
  logic [2:0] m_mask = 3'b111;
  logic m_ie = 0, m_p75 = 0, m_trap = 0, m_sod = 0, m_pt = 0, m_pe = 0;

  function automatic logic [4:0] exp_gnt();
    logic [4:0] el;
    el = {gen & m_ie, l_lo & ~m_mask[0] & m_ie, l_mid & ~m_mask[1] & m_ie,
          m_p75 & ~m_mask[2] & m_ie, m_trap};
    for (int i = 0; i < 5; i++) if (el[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  function automatic logic [15:0] exp_vec(input logic [4:0] g);
    case (g)
      5'b00001: return 16'h0024;
      5'b00010: return 16'h003C;
      5'b00100: return 16'h0034;
      5'b01000: return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input string rq, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h exp %h", tag, rq, act, exp);
    end
  endtask

  // called just after a falling edge: drive, check, advance model to next edge
  task automatic step(input string tag, input logic t, input logic eh,
                      input logic lm, input logic ll, input logic g,
                      input logic a, input logic s_ei, input logic s_di,
                      input logic w, input logic [7:0] d, input logic si);
    logic [4:0] eg;
    logic acc;
    trap = t; e_hi = eh; l_mid = lm; l_lo = ll; gen = g; ack = a;
    ei = s_ei; di = s_di; wr = w; wd = d; sin = si;
    #1;
    eg = exp_gnt();
    acc = a & (eg != 0);
    chk(tag, "R2 req", {15'd0, req}, {15'd0, eg != 0});
    chk(tag, "R2 src", {11'd0, src}, {11'd0, eg});
    chk(tag, "R3 vec", vec, exp_vec(eg));
    chk(tag, "R3 vectored", {15'd0, vtd}, {15'd0, (eg != 0) & ~eg[4]});
    chk(tag, "R11 int_ack", {15'd0, iack}, {15'd0, acc & eg[4]});
    chk(tag, "R10 stat", {8'd0, stat}, {8'd0, si, m_p75, lm, ll, m_ie, m_mask});
    chk(tag, "R9 ser_out", {15'd0, sout}, {15'd0, m_sod});
    m_trap = (t & ~m_pt) | (m_trap & ~(acc & eg[0]));
    m_p75  = (eh & ~m_pe) | (m_p75 & ~(acc & eg[1]) & ~(w & d[4]));
    m_pt = t; m_pe = eh;
    if (acc || s_di) m_ie = 0; else if (s_ei) m_ie = 1;
    if (w && d[3]) m_mask = d[2:0];
    if (w && d[6]) m_sod = d[7];
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    {trap, e_hi, l_mid, l_lo, gen, ack, ei, di, wr, sin} = '0;
    wd = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: masks set, enable low, nothing pending (R4, R5)
    idle("R4_reset");
    // R5: general request ignored while disabled
    step("R5_off", 0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0);
    step("R5_ei", 0, 0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 0);
    // R11: accept general request, R6: enable cleared afterwards
    step("R11_acc", 0, 0, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0);
    step("R6_after", 0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0);
    // R6: accept and enable in same cycle
    step("R6_ei", 0, 0, 0, 0, 1, 0, 1, 0, 0, 8'h00, 0);
    step("R6_race", 0, 0, 0, 0, 1, 1, 1, 0, 0, 8'h00, 0);
    step("R6_race2", 0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 0);
    // R8: unmask all, then a write without bit3 is ignored
    step("R8_load", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h08, 0);
    step("R8_ignore", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h07, 0);
    step("R8_see", 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0);
    // R1/R2: edges on trap and edge source, then all requests at once
    step("R1_edge", 1, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    step("R1_win", 1, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    step("R1_acc", 1, 1, 1, 1, 1, 1, 0, 0, 0, 8'h00, 0);
    step("R5_gate", 0, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    step("R2_ei", 0, 1, 1, 1, 1, 0, 1, 0, 0, 8'h00, 0);
    step("R7_acc", 0, 1, 1, 1, 1, 1, 0, 0, 0, 8'h00, 0);
    step("R2_ei2", 0, 1, 1, 1, 1, 0, 1, 0, 0, 8'h00, 0);
    step("R2_mid", 0, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    // R4: mask mid, lo must win
    step("R4_mask", 0, 1, 1, 1, 1, 0, 0, 0, 1, 8'h0A, 0);
    step("R4_lo", 0, 1, 1, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    // R7: latch set, cleared by write bit4, then edge+clear same cycle
    step("R7_low", 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    step("R7_set", 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    step("R7_clr", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h10, 0);
    step("R7_race", 0, 1, 0, 0, 0, 0, 0, 0, 1, 8'h10, 0);
    step("R7_held", 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 1);
    // R9: serial output qualifier
    step("R9_set", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hC0, 0);
    step("R9_ign", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    step("R9_ign2", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h80, 0);
    step("R9_clr", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h40, 0);
    idle("R9_see");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      step("RND", ($urandom % 16) == 0, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2, $urandom % 3 == 0, $urandom % 3 == 0,
           $urandom % 8 == 0, $urandom % 4 == 0, 8'($urandom), $urandom % 2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got %0d cycles exp < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule